// File: doc/BRIEF.md
# Dependent bank state tracker

This block follows the open or closed state of every bank in one memory device whose neighbouring banks share their sense amplifiers, so that two banks with adjacent indices can never be open together. It watches the row command stream (activate, precharge, and the two refresh forms of those) and a separate stream of precharge requests raised by column operations. It keeps a per-bank open vector and derives from it which shared amplifiers are in use.

A precharge aimed at a bank closes every open bank among that bank and its two neighbours. Closing a bank frees the amplifiers on both of its sides. An activate that would open a bank that is already open, or a bank next to an open one, is refused: the state stays as it was and a one-cycle error pulse is raised. Commands carry a device ID, and only those matching the block's own `dev_id` input are applied.

Top module: `dep_bank_tracker`

## Requirements
- R1: While `rst` is high at a clock edge, every bank is closed after that edge and `act_err` is 0.
- R2: A row command with `row_op` = 2'b00 (activate) to bank B, with banks B-1, B and B+1 all closed, sets `bank_open[B]` at the next edge and leaves every other bank unchanged.
- R3: An activate to bank B while B, B-1 or B+1 is open leaves `bank_open` unchanged and drives `act_err` high for exactly the cycle after the command. `act_err` is never high without such a command.
- R4: A row command with `row_op` = 2'b01 (precharge) to bank B clears every one of banks B-1, B and B+1 that is open, and no other bank. Bank 0 and the top bank have only one neighbour.
- R5: `row_op` = 2'b10 (refresh-activate) behaves exactly like an activate, and 2'b11 (refresh-precharge) behaves exactly like a precharge. Bit 0 of `row_op` alone selects the precharge behaviour.
- R6: A column precharge request (`col_pre_valid`) to bank B acts as a precharge to B. If it arrives in the same cycle as a row command, it is applied first, and the row command is judged against the result.
- R7: A row command or column request whose device field differs from `dev_id` changes no state and raises no error.
- R8: `amp_busy[i]` is high exactly when bank i or bank i+1 is open, for i from 0 to NB-2.
- R9: No two adjacent banks are open at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_id | input | DEVW | This device's ID |
| row_valid | input | 1 | Row command present |
| row_op | input | 2 | 00 activate, 01 precharge, 10 refresh-activate, 11 refresh-precharge |
| row_dev | input | DEVW | Target device of the row command |
| row_bank | input | $clog2(NB) | Target bank of the row command |
| col_pre_valid | input | 1 | Column-side precharge request present |
| col_pre_dev | input | DEVW | Target device of the column request |
| col_pre_bank | input | $clog2(NB) | Target bank of the column request |
| bank_open | output | NB | One bit per bank, 1 = open |
| amp_busy | output | NB-1 | Bit i = amplifier between banks i and i+1 in use |
| act_err | output | 1 | Refused activate, one cycle after the command |

## Verification
A wrong open bit surfaces on `bank_open` and on the two `amp_busy` bits beside that bank one edge after the command that set it. Any later activate near that bank then raises `act_err` when it should not, or fails to raise it when it should. A reference model kept by the bench is compared with all three outputs after every command. This means a corrupted state is caught in the same cycle it appears, before another command can hide it. Long mixed streams of commands across all banks and both device IDs drive the edge banks, the double-neighbour precharge and same-cycle row and column traffic.

// File: rtl/dep_bank_tracker.sv
module dep_bank_tracker #(
  parameter int NB   = 16,
  parameter int DEVW = 5,
  localparam int BW  = $clog2(NB)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [DEVW-1:0] dev_id,
  input  logic            row_valid,
  input  logic [1:0]      row_op,
  input  logic [DEVW-1:0] row_dev,
  input  logic [BW-1:0]   row_bank,
  input  logic            col_pre_valid,
  input  logic [DEVW-1:0] col_pre_dev,
  input  logic [BW-1:0]   col_pre_bank,
  output logic [NB-1:0]   bank_open,
  output logic [NB-2:0]   amp_busy,
  output logic            act_err
);

  function automatic logic [NB-1:0] near(input logic [BW-1:0] b);
    logic [NB-1:0] one;
    one = {{(NB-1){1'b0}}, 1'b1} << b;
    return one | (one << 1) | (one >> 1);
  endfunction

  logic [NB-1:0] open_q, after_col, nxt;
  logic          row_hit, col_hit, is_pre, clash, err_d;

  assign col_hit   = col_pre_valid && (col_pre_dev == dev_id);
  assign row_hit   = row_valid && (row_dev == dev_id);
  assign is_pre    = row_op[0];
  assign after_col = col_hit ? (open_q & ~near(col_pre_bank)) : open_q;
  assign clash     = |(after_col & near(row_bank));
  assign err_d     = row_hit && !is_pre && clash;

  always_comb begin
    nxt = after_col;
    if (row_hit && is_pre)
      nxt = after_col & ~near(row_bank);
    else if (row_hit && !clash)
      nxt = after_col | ({{(NB-1){1'b0}}, 1'b1} << row_bank);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q  <= '0;
      act_err <= 1'b0;
    end else begin
      open_q  <= nxt;
      act_err <= err_d;
    end
  end

  assign bank_open = open_q;

  for (genvar i = 0; i < NB - 1; i++) begin : g_amp
    assign amp_busy[i] = open_q[i] | open_q[i+1];
  end

endmodule

// File: rtl/dep_bank_tracker_chk.sv
module dep_bank_tracker_chk #(
  parameter int NB   = 16,
  parameter int DEVW = 5,
  localparam int BW  = $clog2(NB)
) (
  input logic            clk,
  input logic            rst,
  input logic [DEVW-1:0] dev_id,
  input logic            row_valid,
  input logic [1:0]      row_op,
  input logic [DEVW-1:0] row_dev,
  input logic [BW-1:0]   row_bank,
  input logic            col_pre_valid,
  input logic [DEVW-1:0] col_pre_dev,
  input logic [BW-1:0]   col_pre_bank,
  input logic [NB-1:0]   bank_open,
  input logic [NB-2:0]   amp_busy,
  input logic            act_err
);

  logic rhit, chit;
  assign rhit = row_valid && (row_dev == dev_id);
  assign chit = col_pre_valid && (col_pre_dev == dev_id);

  p_no_adjacent_r9: assert property (@(posedge clk) disable iff (rst)
    (bank_open & (bank_open >> 1)) == '0);

  p_err_source_r3: assert property (@(posedge clk) disable iff (rst)
    act_err |-> $past(rhit && !row_op[0]));

  p_err_nochange_r3: assert property (@(posedge clk) disable iff (rst)
    (act_err && !$past(chit)) |-> bank_open == $past(bank_open));

  p_pre_closes_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(rhit && row_op[0])) |-> !bank_open[$past(row_bank)]);

  p_foreign_idle_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(!rhit && !chit)) |-> (bank_open == $past(bank_open) && !act_err));

endmodule

bind dep_bank_tracker dep_bank_tracker_chk #(.NB(NB), .DEVW(DEVW)) u_chk (
  .clk(clk), .rst(rst), .dev_id(dev_id), .row_valid(row_valid), .row_op(row_op),
  .row_dev(row_dev), .row_bank(row_bank), .col_pre_valid(col_pre_valid),
  .col_pre_dev(col_pre_dev), .col_pre_bank(col_pre_bank), .bank_open(bank_open),
  .amp_busy(amp_busy), .act_err(act_err)
);

// File: tb/dep_bank_tracker_tb.sv
module dep_bank_tracker_tb;
  localparam int NB = 16;
  localparam int DEVW = 5;
  localparam int BW = 4;
  localparam logic [DEVW-1:0] ME = 5'd3;
  localparam logic [DEVW-1:0] OTHER = 5'd9;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic row_valid = 1'b0, col_pre_valid = 1'b0;
  logic [1:0] row_op = 2'b00;
  logic [DEVW-1:0] row_dev = ME, col_pre_dev = ME;
  logic [BW-1:0] row_bank = '0, col_pre_bank = '0;
  logic [NB-1:0] bank_open;
  logic [NB-2:0] amp_busy;
  logic act_err;

  int checks = 0, failures = 0;
  logic [NB-1:0] m = '0;
  logic [31:0] seed = 32'h1234_abcd;

  always #10 clk = ~clk;

  dep_bank_tracker #(.NB(NB), .DEVW(DEVW)) u_dut (
    .clk(clk), .rst(rst), .dev_id(ME), .row_valid(row_valid), .row_op(row_op),
    .row_dev(row_dev), .row_bank(row_bank), .col_pre_valid(col_pre_valid),
    .col_pre_dev(col_pre_dev), .col_pre_bank(col_pre_bank),
    .bank_open(bank_open), .amp_busy(amp_busy), .act_err(act_err));

  function automatic logic [NB-1:0] span(int b);
    logic [NB-1:0] r = '0;
    for (int i = 0; i < NB; i++) if (i >= b - 1 && i <= b + 1) r[i] = 1'b1;
    return r;
  endfunction

  task automatic check(string tag, logic [NB-1:0] exp_open, logic exp_err);
    logic [NB-2:0] exp_amp;
    for (int i = 0; i < NB - 1; i++) exp_amp[i] = exp_open[i] | exp_open[i+1];
    checks++;
    if (bank_open !== exp_open || act_err !== exp_err || amp_busy !== exp_amp) begin
      failures++;
      $display("FAIL %s open=%h err=%b amp=%h expected open=%h err=%b amp=%h",
               tag, bank_open, act_err, amp_busy, exp_open, exp_err, exp_amp);
    end
  endtask

  task automatic step(string tag, logic v, logic [1:0] op, logic [DEVW-1:0] d, int b,
                      logic cv, logic [DEVW-1:0] cd, int cb);
    logic e = 1'b0;
    row_valid = v; row_op = op; row_dev = d; row_bank = BW'(b);
    col_pre_valid = cv; col_pre_dev = cd; col_pre_bank = BW'(cb);
    if (cv && cd == ME) m &= ~span(cb);
    if (v && d == ME) begin
      if (op[0]) m &= ~span(b);
      else if ((m & span(b)) != '0) e = 1'b1;
      else m[b] = 1'b1;
    end
    @(negedge clk);
    row_valid = 1'b0; col_pre_valid = 1'b0;
    check(tag, m, e);
  endtask

  initial begin
    #4_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R1 reset", '0, 1'b0);
    rst = 1'b0;

    for (int b = 0; b < NB; b++) begin
      step("R2 act", 1, 2'b00, ME, b, 0, ME, 0);
      if (b > 0) step("R3 act left nbr", 1, 2'b00, ME, b - 1, 0, ME, 0);
      step("R3 act self", 1, 2'b10, ME, b, 0, ME, 0);
      if (b < NB - 1) step("R3 act right nbr", 1, 2'b00, ME, b + 1, 0, ME, 0);
      if (b < NB - 1) step("R4 pre right side", 1, 2'b01, ME, b + 1, 0, ME, 0);
      else step("R4 pre top", 1, 2'b01, ME, b, 0, ME, 0);
      step("R8 idle", 0, 2'b00, ME, 0, 0, ME, 0);
    end

    step("R2 act 4", 1, 2'b00, ME, 4, 0, ME, 0);
    step("R2 act 6", 1, 2'b00, ME, 6, 0, ME, 0);
    step("R4 pre middle closes both", 1, 2'b01, ME, 5, 0, ME, 0);
    step("R5 refa", 1, 2'b10, ME, 0, 0, ME, 0);
    step("R5 refp left edge", 1, 2'b11, ME, 1, 0, ME, 0);
    step("R2 act 7", 1, 2'b00, ME, 7, 0, ME, 0);
    step("R6 col pre then act nbr", 1, 2'b00, ME, 8, 1, ME, 7);
    step("R7 foreign act", 1, 2'b00, OTHER, 9, 0, ME, 0);
    step("R7 foreign pre", 1, 2'b01, OTHER, 8, 1, OTHER, 8);
    step("R6 col pre only", 0, 2'b00, ME, 0, 1, ME, 9);

    for (int n = 0; n < 3000; n++) begin
      logic [1:0] op;
      seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5);
      op = seed[1:0];
      step(op[0] ? "R4 R5 R9 random pre" : "R2 R3 R5 R9 random act",
           seed[2] | seed[3], op, (seed[4:2] == 3'd0) ? OTHER : ME, int'(seed[11:8]),
           seed[12:5] < 8'd40, (seed[14:13] == 2'd0) ? OTHER : ME, int'(seed[19:16]));
    end

    rst = 1'b1;
    @(negedge clk);
    m = '0;
    check("R1 reset again", '0, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule